// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header. The bus interface logic sends it single-cycle event pulses: a parity error was seen, the system-error output was driven, and master or target aborts were received or signalled. Each such event sets a sticky flag, and that flag stays set until software clears it. Software reads the word at any time. A write can only clear flags: a 1 in a clearable bit position clears that bit, and nothing can be set by a write.

The data-parity flag is qualified. It sets only when three things hold in the same cycle: the parity-error line is active, the function owns the bus as master, and the command register's parity-response enable is on. The rest of the word is not writable. Two capability flags follow strap inputs. The device-select timing field is fixed at medium. All other bits read zero.

Writes are qualified per byte lane. An event and a clear that reach the same bit in the same cycle leave the bit set, so no event is lost. Reset is synchronous and active high.

Top module: `pcistat_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every sticky bit (15, 14, 13, 12, 11, 8) becomes 0 after that edge.
- R2: Bit 15 becomes 1 after any edge at which `ev_perr_detected` is high, whatever the value of `cmd_perr_resp`.
- R3: After an edge with the matching pulse high, the matching bit becomes 1: `ev_serr_driven` sets bit 14, `ev_master_abort` sets bit 13, `ev_tabort_rcvd` sets bit 12, and `ev_tabort_sig` sets bit 11.
- R4: Bit 8 becomes 1 after an edge only when `perr_line`, `is_master` and `cmd_perr_resp` are all high at that edge. Any other combination leaves it unchanged.
- R5: A write (`wr_en` high) with `wr_be[1]` high clears each sticky bit whose `wr_data` bit is 1. Sticky bits whose `wr_data` bit is 0 are unchanged. With `wr_be[1]` low the write changes nothing.
- R6: When a set event and a clearing write reach the same bit at the same edge, the bit is 1 after that edge.
- R7: Bits 10:9 always read 2'b01.
- R8: Bit 7 reads `strap_fbb` and bit 4 reads `strap_pm`, combinationally. Writes to these bits have no effect.
- R9: Bits 6, 5 and 3:0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables, bit 1 for bits 15:8 |
| wr_data | input | 16 | Write data; 1 clears a sticky bit |
| rd_data | output | 16 | Current status word |
| ev_perr_detected | input | 1 | Pulse: a parity error was detected |
| ev_serr_driven | input | 1 | Pulse: the system-error output was driven |
| ev_master_abort | input | 1 | Pulse: a master transaction ended in master abort |
| ev_tabort_rcvd | input | 1 | Pulse: a master transaction was ended by target abort |
| ev_tabort_sig | input | 1 | Pulse: this function ended a transaction with target abort |
| perr_line | input | 1 | Parity-error signal active (from this or another agent) |
| is_master | input | 1 | This function is bus master for the transaction |
| cmd_perr_resp | input | 1 | Command register parity-response enable |
| strap_fbb | input | 1 | Fast back-to-back capable strap |
| strap_pm | input | 1 | Power-management enable strap (capability list present) |

## Verification
The collision of interest is an event pulse and a software clear reaching the same sticky bit at the same edge. The bench provokes it by driving a clearing write with ones in all sticky positions while pulsing one event, and then several events at once. The bench's reference model applies the clear before the set on every clock. The read word must show the colliding bit still set and every other cleared bit at 0.

// File: rtl/pcistat_pkg.sv
package pcistat_pkg;

    localparam int REG_W   = 16;
    localparam int LANES   = REG_W / 8;

    localparam int B_DPE   = 15;
    localparam int B_SSE   = 14;
    localparam int B_RMA   = 13;
    localparam int B_RTA   = 12;
    localparam int B_STA   = 11;
    localparam int B_DSEL0 = 9;
    localparam int B_DPD   = 8;
    localparam int B_FBB   = 7;
    localparam int B_CAP   = 4;

    localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;

    typedef struct packed {
        logic perr_detected;
        logic serr_driven;
        logic master_abort;
        logic tabort_rcvd;
        logic tabort_sig;
        logic perr_line;
        logic is_master;
        logic perr_resp;
    } bus_evt_t;

    typedef struct packed {
        logic fbb;
        logic pm;
    } strap_t;

    function automatic logic [REG_W-1:0] sticky_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_DPE] = 1'b1;
        m[B_SSE] = 1'b1;
        m[B_RMA] = 1'b1;
        m[B_RTA] = 1'b1;
        m[B_STA] = 1'b1;
        m[B_DPD] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] lane_expand(input logic [LANES-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) m[i] = be[i/8];
        return m;
    endfunction

endpackage

// File: rtl/pcistat_evt_qual.sv
module pcistat_evt_qual
    import pcistat_pkg::*;
(
    input  bus_evt_t          ev,
    output logic [REG_W-1:0]  set_vec
);
    always_comb begin
        set_vec        = '0;
        set_vec[B_DPE] = ev.perr_detected;
        set_vec[B_SSE] = ev.serr_driven;
        set_vec[B_RMA] = ev.master_abort;
        set_vec[B_RTA] = ev.tabort_rcvd;
        set_vec[B_STA] = ev.tabort_sig;
        // R4: all three conditions together
        set_vec[B_DPD] = ev.perr_line & ev.is_master & ev.perr_resp;
    end
endmodule

// File: rtl/pcistat_sticky_bit.sv
module pcistat_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (!set_i && clr_i) |=> !q);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/pcistat_sticky_bank.sv
module pcistat_sticky_bank
    import pcistat_pkg::*;
#(
    parameter int               W    = REG_W,
    parameter logic [W-1:0]     MASK = '0
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            pcistat_sticky_bit u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q     (q[i])
            );
        end else begin : g_none
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pcistat_readmux.sv
module pcistat_readmux
    import pcistat_pkg::*;
(
    input  logic [REG_W-1:0] sticky_q,
    input  strap_t           strap,
    output logic [REG_W-1:0] word
);
    localparam logic [REG_W-1:0] SMASK = sticky_mask();

    always_comb begin
        word                       = sticky_q & SMASK;
        word[B_DSEL0+1:B_DSEL0]    = DEVSEL_MEDIUM;
        word[B_FBB]                = strap.fbb;
        word[B_CAP]                = strap.pm;
    end
endmodule

// File: rtl/pcistat_reg.sv
module pcistat_reg
    import pcistat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LANES-1:0]    wr_be,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                ev_perr_detected,
    input  logic                ev_serr_driven,
    input  logic                ev_master_abort,
    input  logic                ev_tabort_rcvd,
    input  logic                ev_tabort_sig,
    input  logic                perr_line,
    input  logic                is_master,
    input  logic                cmd_perr_resp,
    input  logic                strap_fbb,
    input  logic                strap_pm
);
    localparam logic [REG_W-1:0] SMASK = sticky_mask();

    bus_evt_t         ev;
    strap_t           strap;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] sticky_q;

    assign ev = '{perr_detected: ev_perr_detected, serr_driven: ev_serr_driven,
                  master_abort: ev_master_abort, tabort_rcvd: ev_tabort_rcvd,
                  tabort_sig: ev_tabort_sig, perr_line: perr_line,
                  is_master: is_master, perr_resp: cmd_perr_resp};
    assign strap = '{fbb: strap_fbb, pm: strap_pm};

    assign clr_vec = wr_en ? (wr_data & lane_expand(wr_be) & SMASK) : '0;

    pcistat_evt_qual u_qual (
        .ev      (ev),
        .set_vec (set_vec)
    );

    pcistat_sticky_bank #(.W(REG_W), .MASK(SMASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (sticky_q)
    );

    pcistat_readmux u_mux (
        .sticky_q (sticky_q),
        .strap    (strap),
        .word     (rd_data)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> ((rd_data & SMASK) == '0));
    a_r2_dpe_any: assert property (@(posedge clk) disable iff (rst)
        ev_perr_detected |=> rd_data[B_DPE]);
    a_r4_dpd_sets: assert property (@(posedge clk) disable iff (rst)
        (perr_line && is_master && cmd_perr_resp) |=> rd_data[B_DPD]);
    a_r4_dpd_needs_resp: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[B_DPD] && !cmd_perr_resp) |=> !rd_data[B_DPD]);
    a_r4_dpd_needs_master: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[B_DPD] && !is_master) |=> !rd_data[B_DPD]);
    a_r5_lane_gate: assert property (@(posedge clk) disable iff (rst)
        (!wr_be[1] && (set_vec == '0)) |=> $stable(rd_data[15:11]));
endmodule

// File: tb/test_pcistat_reg.sv
module test_pcistat_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        e_dpe, e_sse, e_rma, e_rta, e_sta;
    logic        perr_line, is_master, perr_resp;
    logic        s_fbb, s_pm;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [15:0] mdl = 16'h0;

    always #4 clk = ~clk;

    pcistat_reg i_pcistat_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .ev_perr_detected(e_dpe), .ev_serr_driven(e_sse),
        .ev_master_abort(e_rma), .ev_tabort_rcvd(e_rta), .ev_tabort_sig(e_sta),
        .perr_line(perr_line), .is_master(is_master), .cmd_perr_resp(perr_resp),
        .strap_fbb(s_fbb), .strap_pm(s_pm)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] expect_word();
        logic [15:0] e;
        e = mdl;
        e[10:9] = 2'b01;
        e[7] = s_fbb;
        e[4] = s_pm;
        return e;
    endfunction

    task automatic quiet();
        wr_en = 0; wr_be = 2'b00; wr_data = 16'h0;
        e_dpe = 0; e_sse = 0; e_rma = 0; e_rta = 0; e_sta = 0;
        perr_line = 0; is_master = 0; perr_resp = 0;
    endtask

    // one clock: model update at the edge, compare at the following falling edge
    task automatic tick(input string tag);
        logic [15:0] e;
        @(posedge clk);
        if (rst) mdl = 16'h0;
        else begin
            if (wr_en && wr_be[1]) begin
                for (int b = 8; b < 16; b++)
                    if (wr_data[b] && (b == 8 || b >= 11)) mdl[b] = 1'b0;
            end
            if (e_dpe) mdl[15] = 1'b1;
            if (e_sse) mdl[14] = 1'b1;
            if (e_rma) mdl[13] = 1'b1;
            if (e_rta) mdl[12] = 1'b1;
            if (e_sta) mdl[11] = 1'b1;
            if (perr_line && is_master && perr_resp) mdl[8] = 1'b1;
        end
        @(negedge clk);
        e = expect_word();
        n_tests++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, rd_data, e);
        end
        quiet();
    endtask

    task automatic clear_all(input string tag);
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
        tick(tag);
    endtask

    initial begin
        quiet();
        s_fbb = 0; s_pm = 0;
        rst = 1;
        @(negedge clk);
        tick("R1 reset");
        rst = 0;
        tick("R1 idle after reset, R7 R9 fixed bits");

        e_dpe = 1;                     tick("R2 parity detected, resp off");
        clear_all("R5 clear bit15");
        e_dpe = 1; perr_resp = 1;      tick("R2 parity detected, resp on");
        e_sse = 1;                     tick("R3 system error bit14");
        e_rma = 1;                     tick("R3 master abort bit13");
        e_rta = 1;                     tick("R3 target abort rcvd bit12");
        e_sta = 1;                     tick("R3 target abort signalled bit11");
        clear_all("R5 clear all");

        // R4: every combination of the three conditions
        for (int k = 0; k < 8; k++) begin
            perr_line = k[0]; is_master = k[1]; perr_resp = k[2];
            tick("R4 parity qualifier combo");
            clear_all("R4 clear after combo");
        end

        // R5: selective clear, byte lanes
        e_sse = 1; e_rma = 1; e_rta = 1; e_sta = 1; e_dpe = 1;
        perr_line = 1; is_master = 1; perr_resp = 1;
        tick("R3 set all sticky");
        wr_en = 1; wr_be = 2'b01; wr_data = 16'hFFFF;  tick("R5 lane1 disabled, no clear");
        wr_en = 0; wr_be = 2'b11; wr_data = 16'hFFFF;  tick("R5 no strobe, no clear");
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h2100;  tick("R5 clear bits 13 and 8 only");
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h0000;  tick("R5 zeros leave bits");
        wr_en = 1; wr_be = 2'b10; wr_data = 16'h5800;  tick("R5 clear bits 14 12 11");

        // R6: collisions
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; e_rma = 1;
        tick("R6 master abort vs clear");
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
        e_dpe = 1; e_sta = 1; perr_line = 1; is_master = 1; perr_resp = 1;
        tick("R6 multi set vs clear");
        clear_all("R5 clear after collision");

        // R8: straps and write immunity
        s_fbb = 1; tick("R8 fbb strap high");
        s_pm = 1;  tick("R8 pm strap high");
        wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; tick("R8 R9 write ones to fixed bits");
        s_fbb = 0; tick("R8 fbb strap low");
        wr_en = 1; wr_be = 2'b11; wr_data = 16'h0000; tick("R7 R9 write zeros");

        // R1: reset during activity
        e_sse = 1; e_dpe = 1; tick("R3 set before reset");
        rst = 1; e_rta = 1; tick("R1 reset beats events");
        rst = 0; tick("R1 after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule